// File: doc/BRIEF.md
# Isochronous Schedule Insertion-Point Calculator

This block tells scheduling logic how close to a running periodic-schedule engine it may place new isochronous work. For each request it takes a sampled frame index and a threshold field. The frame index holds an 11-bit frame number above a 3-bit micro-frame number. The threshold field says how much schedule state the engine may hold on chip. The block returns the earliest frame and micro-frame at which new work cannot collide with state the engine has already cached. It also reports which caching model it applied.

The sampled index is never taken at face value. The engine may be anywhere inside the sampled micro-frame, so the block first moves the position one micro-frame ahead, with a carry into the frame number. Three cases follow from the threshold field:
- With no caching, the safe point is one micro-frame beyond that adjusted position.
- With whole-frame caching, the safe point is the start of the frame after the adjusted one.
- With a window of N cached micro-frames, the safe point is N + 1 micro-frames beyond the adjusted position.

All frame arithmetic wraps at 2048. Requests use a valid/ready handshake. The answer is registered and appears on the cycle after acceptance.

Top module: `iso_insert_calc`

## Requirements
- R1: When every bit of the threshold is 0, the result equals the sampled index plus 2 micro-frames, with a carry from the micro-frame field into the frame field, and the mode output is 0 (no caching).
- R2: When threshold bit 7 is 1, whole-frame caching applies whatever the other bits hold, and the mode output is 1.
- R3: In whole-frame caching with a sampled micro-frame of 0 to 6, the result frame is the sampled frame plus 1 and the result micro-frame is 0.
- R4: In whole-frame caching with a sampled micro-frame of 7, the result frame is the sampled frame plus 2 and the result micro-frame is 0.
- R5: When threshold bit 7 is 0 and threshold bits 2:0 hold a non-zero N, the result equals the sampled index plus N + 2 micro-frames, with carry, and the mode output is 2 (micro-frame caching).
- R6: All frame results wrap modulo 2048. The combined 14-bit position wraps modulo 16384.
- R7: A request accepted on a clock edge (req_valid and req_ready both high) produces rsp_valid high on the following cycle, carrying its result. In a cycle after an edge with no acceptance, rsp_valid is low and the result outputs keep their last values.
- R8: While rst is high, req_ready is low. A synchronous active-high reset clears rsp_valid, rsp_frame, rsp_uframe and rsp_mode to 0.
- R9: Threshold bits 6:3 have no effect on the result or the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request (low in reset) |
| req_index | input | 14 | Sampled index: frame in bits 13:3, micro-frame in bits 2:0 |
| req_thresh | input | 8 | Threshold: bit 7 selects frame caching, bits 2:0 give the window count |
| rsp_valid | output | 1 | Result valid, one cycle per accepted request |
| rsp_frame | output | 11 | Earliest safe frame |
| rsp_uframe | output | 3 | Earliest safe micro-frame |
| rsp_mode | output | 2 | 0 no caching, 1 frame caching, 2 micro-frame caching |

## Verification
The result register is loaded only on acceptance. A wrong mode decode or a dropped carry therefore shows at the ports on the cycle right after the offending request. It stays visible until the next request overwrites it.

The reference model predicts every output on every cycle. An idle cycle that corrupts the held values is therefore caught on that same cycle, and so is a spurious or missing rsp_valid pulse.

The directed cases cover:
- micro-frame 7 in each mode;
- frame 2047 wrapping to frame 0;
- threshold values whose middle bits are set.

// File: rtl/iso_ins_pkg.sv
package iso_ins_pkg;

   typedef enum logic [1:0] {
      ISO_MODE_NONE   = 2'd0,
      ISO_MODE_FRAME  = 2'd1,
      ISO_MODE_UFRAME = 2'd2
   } iso_mode_e;

   localparam int ISO_MODE_COUNT = 3;

endpackage

// File: rtl/iso_mode_decode.sv
module iso_mode_decode
   import iso_ins_pkg::*;
#(
   parameter int THR_W = 8,
   parameter int UF_W  = 3
) (
   input  logic [THR_W-1:0] thresh,
   output iso_mode_e        mode,
   output logic [UF_W-1:0]  win_cnt
);

   localparam int TOP_BIT = THR_W - 1;

   initial begin
      if (THR_W < UF_W + 1)
         $fatal(1, "iso_mode_decode: THR_W too small for UF_W");
   end

   assign win_cnt = thresh[UF_W-1:0];

   always_comb begin
      if (thresh[TOP_BIT])
         mode = ISO_MODE_FRAME;
      else if (win_cnt != '0)
         mode = ISO_MODE_UFRAME;
      else
         mode = ISO_MODE_NONE;
   end

endmodule

// File: rtl/iso_pos_adjust.sv
module iso_pos_adjust #(
   parameter int POS_W  = 14,
   parameter int UNCERT = 1
) (
   input  logic [POS_W-1:0] pos_in,
   output logic [POS_W-1:0] pos_out
);

   localparam logic [POS_W-1:0] UNCERT_V = POS_W'(UNCERT);

   initial begin
      if (UNCERT < 0)
         $fatal(1, "iso_pos_adjust: UNCERT must be non-negative");
   end

   assign pos_out = pos_in + UNCERT_V;

endmodule

// File: rtl/iso_safe_point.sv
module iso_safe_point
   import iso_ins_pkg::*;
#(
   parameter int FRAME_W  = 11,
   parameter int UF_W     = 3,
   parameter int NONE_GAP = 1,
   parameter int WIN_GAP  = 1
) (
   input  logic [FRAME_W+UF_W-1:0] adj_pos,
   input  iso_mode_e               mode,
   input  logic [UF_W-1:0]         win_cnt,
   output logic [FRAME_W+UF_W-1:0] safe_pos
);

   localparam int POS_W = FRAME_W + UF_W;
   localparam logic [POS_W-1:0]   NONE_V  = POS_W'(NONE_GAP);
   localparam logic [POS_W-1:0]   WIN_V   = POS_W'(WIN_GAP);
   localparam logic [FRAME_W-1:0] FRM_ONE = FRAME_W'(1);

   logic [POS_W-1:0] cand [ISO_MODE_COUNT];

   for (genvar g = 0; g < ISO_MODE_COUNT; g++) begin : g_cand
      if (g == int'(ISO_MODE_FRAME)) begin : g_frame
         logic [FRAME_W-1:0] nxt_frame;
         assign nxt_frame = adj_pos[POS_W-1:UF_W] + FRM_ONE;
         assign cand[g]   = {nxt_frame, {UF_W{1'b0}}};
      end else if (g == int'(ISO_MODE_UFRAME)) begin : g_window
         assign cand[g] = adj_pos + POS_W'(win_cnt) + WIN_V;
      end else begin : g_none
         assign cand[g] = adj_pos + NONE_V;
      end
   end

   always_comb begin
      unique case (mode)
         ISO_MODE_FRAME:  safe_pos = cand[int'(ISO_MODE_FRAME)];
         ISO_MODE_UFRAME: safe_pos = cand[int'(ISO_MODE_UFRAME)];
         default:         safe_pos = cand[int'(ISO_MODE_NONE)];
      endcase
   end

endmodule

// File: rtl/iso_insert_calc.sv
module iso_insert_calc
   import iso_ins_pkg::*;
#(
   parameter int FRAME_W = 11,
   parameter int UF_W    = 3,
   parameter int THR_W   = 8,
   parameter int UNCERT  = 1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       req_valid,
   output logic                       req_ready,
   input  logic [FRAME_W+UF_W-1:0]    req_index,
   input  logic [THR_W-1:0]           req_thresh,
   output logic                       rsp_valid,
   output logic [FRAME_W-1:0]         rsp_frame,
   output logic [UF_W-1:0]            rsp_uframe,
   output logic [1:0]                 rsp_mode
);

   localparam int POS_W = FRAME_W + UF_W;

   initial begin
      if (FRAME_W < 1 || UF_W < 1)
         $fatal(1, "iso_insert_calc: field widths must be positive");
   end

   logic             accept;
   logic [POS_W-1:0] adj_pos;
   logic [POS_W-1:0] safe_pos;
   iso_mode_e        mode;
   logic [UF_W-1:0]  win_cnt;

   assign req_ready = ~rst;
   assign accept    = req_valid & req_ready;

   iso_mode_decode #(.THR_W(THR_W), .UF_W(UF_W)) dec_i (
      .thresh  (req_thresh),
      .mode    (mode),
      .win_cnt (win_cnt)
   );

   iso_pos_adjust #(.POS_W(POS_W), .UNCERT(UNCERT)) adj_i (
      .pos_in  (req_index),
      .pos_out (adj_pos)
   );

   iso_safe_point #(.FRAME_W(FRAME_W), .UF_W(UF_W), .NONE_GAP(1), .WIN_GAP(1)) sp_i (
      .adj_pos  (adj_pos),
      .mode     (mode),
      .win_cnt  (win_cnt),
      .safe_pos (safe_pos)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         rsp_valid  <= 1'b0;
         rsp_frame  <= '0;
         rsp_uframe <= '0;
         rsp_mode   <= 2'd0;
      end else begin
         rsp_valid <= accept;
         if (accept) begin
            rsp_frame  <= safe_pos[POS_W-1:UF_W];
            rsp_uframe <= safe_pos[UF_W-1:0];
            rsp_mode   <= mode;
         end
      end
   end

endmodule

// File: rtl/iso_insert_chk.sv
module iso_insert_chk
   import iso_ins_pkg::*;
#(
   parameter int FRAME_W = 11,
   parameter int UF_W    = 3,
   parameter int THR_W   = 8
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    req_valid,
   input logic                    req_ready,
   input logic [FRAME_W+UF_W-1:0] req_index,
   input logic [THR_W-1:0]        req_thresh,
   input logic                    rsp_valid,
   input logic [FRAME_W-1:0]      rsp_frame,
   input logic [UF_W-1:0]         rsp_uframe,
   input logic [1:0]              rsp_mode
);

   localparam int POS_W = FRAME_W + UF_W;

   logic acc;
   assign acc = req_valid && req_ready;

   // R7
   acc_to_rsp_chk: assert property (@(posedge clk) disable iff (rst)
      acc |=> rsp_valid);

   // R7
   idle_no_rsp_chk: assert property (@(posedge clk) disable iff (rst)
      !acc |=> (!rsp_valid && $stable(rsp_frame) && $stable(rsp_uframe) && $stable(rsp_mode)));

   // R1
   nocache_sum_chk: assert property (@(posedge clk) disable iff (rst)
      (acc && req_thresh == '0) |=>
         ({rsp_frame, rsp_uframe} == $past(req_index) + POS_W'(2) && rsp_mode == 2'd0));

   // R2
   frame_mode_chk: assert property (@(posedge clk) disable iff (rst)
      (acc && req_thresh[THR_W-1]) |=> rsp_mode == 2'(ISO_MODE_FRAME));

   // R3
   frame_uf_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && rsp_mode == 2'(ISO_MODE_FRAME)) |-> rsp_uframe == '0);

   // R5
   mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |-> rsp_mode != 2'd3);

endmodule

bind iso_insert_calc iso_insert_chk #(
   .FRAME_W(FRAME_W), .UF_W(UF_W), .THR_W(THR_W)
) chk_i (
   .clk        (clk),
   .rst        (rst),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_index  (req_index),
   .req_thresh (req_thresh),
   .rsp_valid  (rsp_valid),
   .rsp_frame  (rsp_frame),
   .rsp_uframe (rsp_uframe),
   .rsp_mode   (rsp_mode)
);

// File: tb/iso_insert_calc_tb_top.sv
`timescale 1ns/1ps
module iso_insert_calc_tb_top;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [13:0] req_index = '0;
   logic [7:0]  req_thresh = '0;
   logic        rsp_valid;
   logic [10:0] rsp_frame;
   logic [2:0]  rsp_uframe;
   logic [1:0]  rsp_mode;

   iso_insert_calc dut_i (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_index(req_index), .req_thresh(req_thresh), .rsp_valid(rsp_valid),
      .rsp_frame(rsp_frame), .rsp_uframe(rsp_uframe), .rsp_mode(rsp_mode)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // behavioural model state
   int    m_valid = 0, m_frame = 0, m_uf = 0, m_mode = 0;
   string m_tag = "R8";

   function automatic void ref_calc(input int idx, input int thr,
                                    output int f, output int u, output int md,
                                    output string tag);
      int tot;
      int n;
      n = thr % 8;
      if ((thr / 128) % 2 == 1) begin
         tot = (idx + 1) / 8 + 1;
         f   = tot % 2048;
         u   = 0;
         md  = 1;
         tag = (idx % 8 == 7) ? "R4/R2" : "R3/R2";
         if (tot >= 2048) tag = {tag, "/R6"};
      end else begin
         tot = (n == 0) ? idx + 2 : idx + 2 + n;
         md  = (n == 0) ? 0 : 2;
         tag = (n == 0) ? "R1" : "R5";
         if (tot >= 16384) tag = {tag, "/R6"};
         tot = tot % 16384;
         f   = tot / 8;
         u   = tot % 8;
      end
      if ((thr / 8) % 16 != 0) tag = {tag, "/R9"};
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_valid = 0; m_frame = 0; m_uf = 0; m_mode = 0; m_tag = "R8";
      end else if (req_valid) begin
         ref_calc(int'(req_index), int'(req_thresh), m_frame, m_uf, m_mode, m_tag);
         m_valid = 1;
      end else begin
         m_valid = 0;
         m_tag = "R7";
      end
   end

   // compare on every cycle, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         string tag;
         tag = rst ? "R8" : m_tag;
         checks++;
         if (int'(rsp_valid) != m_valid || int'(rsp_frame) != m_frame ||
             int'(rsp_uframe) != m_uf || int'(rsp_mode) != m_mode) begin
            errors++;
            $display("FAIL %s: got v=%0d f=%0d u=%0d m=%0d expected v=%0d f=%0d u=%0d m=%0d",
                     tag, rsp_valid, rsp_frame, rsp_uframe, rsp_mode,
                     m_valid, m_frame, m_uf, m_mode);
         end
         checks++;
         if (req_ready !== !rst) begin
            errors++;
            $display("FAIL R8: req_ready got %0b expected %0b", req_ready, !rst);
         end
      end
   end

   task automatic drive(input logic v, input int frame, input int uf, input int thr);
      @(negedge clk);
      #1;
      req_valid  = v;
      req_index  = 14'(frame * 8 + uf);
      req_thresh = 8'(thr);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(1'b0, 0, 0, 0);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #2000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      // R8 reset state
      repeat (3) @(negedge clk);
      #1 rst = 1'b0;
      idle(2);
      // R1 no caching, with and without carry
      drive(1, 5, 3, 8'h00);
      drive(1, 5, 7, 8'h00);
      drive(1, 5, 6, 8'h00);
      idle(2);                         // R7 hold
      // R3 / R4 / R2 frame caching
      drive(1, 5, 3, 8'h80);
      drive(1, 5, 6, 8'h80);
      drive(1, 5, 7, 8'h80);
      drive(1, 9, 0, 8'h87);
      // R5 micro-frame window
      drive(1, 5, 3, 8'h02);
      drive(1, 5, 7, 8'h07);
      drive(1, 0, 0, 8'h01);
      // R6 wrap
      drive(1, 2047, 7, 8'h00);
      drive(1, 2047, 7, 8'h80);
      drive(1, 2047, 2, 8'h80);
      drive(1, 2047, 6, 8'h07);
      // R9 middle bits ignored
      drive(1, 100, 4, 8'h78);
      drive(1, 100, 4, 8'h7A);
      drive(1, 100, 4, 8'hF8);
      idle(1);
      // R8 reset in the middle of traffic
      drive(1, 33, 1, 8'h03);
      @(negedge clk); #1 rst = 1'b1;
      drive(1, 44, 2, 8'h00);
      @(negedge clk); #1 rst = 1'b0; req_valid = 1'b0;
      idle(2);
      // mixed traffic
      for (int i = 0; i < 4000; i++) begin
         int sel;
         sel = $urandom_range(0, 9);
         drive(sel < 7, $urandom_range(0, 2047), $urandom_range(0, 7),
               $urandom_range(0, 255));
      end
      idle(3);
      finish_run();
   end

endmodule